// File: doc/BRIEF.md
# Two-Channel Interrupt Request Arbiter

This block gathers the transmit and external/status interrupt sources of a two-channel serial controller into a single interrupt request line. It also produces a 4-bit code naming the winning source. Each source has an enable flag and a pending flag, and it competes only when both are set. A master enable gates the whole block. When the master enable is off, no request is raised and the type code reads NONE.

The request line and the type code are registered. Each one is reloaded only when its newly computed value differs from the stored one, so the interrupt controller downstream never sees a redundant edge. A one-cycle acknowledge pulse masks the request for that cycle and leaves every pending flag alone. The block also holds an interrupt vector byte that the host writes. The vector is returned unchanged for the CPU's interrupt-acknowledge cycle.

Top module: `irq_arbiter`

## Requirements
- R1: A source takes part in arbitration only when its enable bit and its pending bit are both 1. Either bit alone raises no request.
- R2: When several sources are active, the winner is chosen in this fixed order, highest first: channel B transmit, channel A transmit, channel B external/status, channel A external/status. Channel index 0 is A and index 1 is B.
- R3: The type code is 4 bits wide. NONE=0, A transmit=5, B transmit=6, A external/status=7, B external/status=8.
- R4: While `master_en` is 0 at a clock edge, `irq_req` is 0 and `irq_type` is NONE after that edge, whatever the sources are doing.
- R5: `irq_req` and `irq_type` are registered. They reflect the inputs sampled at the previous rising edge, and they change only when the computed value differs from the held one.
- R6: When `irq_ack` is 1 at an edge, `irq_req` is 0 after that edge. The type code and all pending state are unaffected, so the request comes back on the next edge if the source is still active.
- R7: When `vec_we` is 1 at an edge, `irq_vector` takes `vec_wdata`. Otherwise it holds its value.
- R8: A synchronous reset clears `irq_req`, sets `irq_type` to NONE and clears `irq_vector`.
- R9: With `master_en` at 1 and no source active, `irq_req` is 0 and `irq_type` is NONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Master interrupt enable |
| tx_irq_en | input | 2 | Transmit interrupt enable per channel (bit 0 = A, bit 1 = B) |
| tx_irq_pend | input | 2 | Transmit interrupt pending per channel |
| ext_irq_en | input | 2 | External/status interrupt enable per channel |
| ext_irq_pend | input | 2 | External/status interrupt pending per channel |
| irq_ack | input | 1 | Acknowledge pulse; masks the request for one cycle |
| vec_we | input | 1 | Vector byte write strobe |
| vec_wdata | input | 8 | Vector byte to store |
| irq_req | output | 1 | Registered interrupt request |
| irq_type | output | 4 | Registered code of the winning source |
| irq_vector | output | 8 | Stored interrupt vector |

## Verification
The hardest case to reach from the ports is the interplay of acknowledge, master enable and a change of winner. In that case the request must drop for exactly one cycle while the type code keeps tracking the sources, and then rise again without a missing or extra edge. The stimulus sweeps all 256 combinations of the eight enable and pending bits to exercise the full ranking. It then pulses the acknowledge while a source stays active and toggles the master enable with every source asserted. A long random phase then mixes acknowledges, master toggles and vector writes. Every cycle is compared against a behavioural model.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int unsigned TYPE_W  = 4;
  localparam int unsigned TX_BASE = 5;
  localparam logic [TYPE_W-1:0] TYPE_NONE = '0;
endpackage

// File: rtl/irqarb_gate.sv
module irqarb_gate #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] tx_en,
  input  logic [NUM_CH-1:0] tx_pend,
  input  logic [NUM_CH-1:0] ext_en,
  input  logic [NUM_CH-1:0] ext_pend,
  output logic [NUM_CH-1:0] tx_act,
  output logic [NUM_CH-1:0] ext_act
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign tx_act[c]  = tx_en[c]  & tx_pend[c];
    assign ext_act[c] = ext_en[c] & ext_pend[c];
  end
endmodule

// File: rtl/irqarb_prio.sv
module irqarb_prio
  import irqarb_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] tx_act,
  input  logic [NUM_CH-1:0] ext_act,
  input  logic              master_en,
  output logic [TYPE_W-1:0] code_nxt,
  output logic              req_any
);
  localparam int unsigned NSRC     = 2 * NUM_CH;
  localparam int unsigned EXT_BASE = TX_BASE + NUM_CH;

  logic [NSRC-1:0]   ranked;
  logic [TYPE_W-1:0] code_tbl [NSRC];

  // rank 0 is highest: transmit class first, higher channel index first
  for (genvar r = 0; r < NSRC; r++) begin : g_rank
    if (r < NUM_CH) begin : g_tx
      localparam int CODE = TX_BASE + (NUM_CH - 1 - r);
      assign ranked[r]   = tx_act[NUM_CH-1-r];
      assign code_tbl[r] = CODE[TYPE_W-1:0];
    end else begin : g_ext
      localparam int CODE = EXT_BASE + (NSRC - 1 - r);
      assign ranked[r]   = ext_act[NSRC-1-r];
      assign code_tbl[r] = CODE[TYPE_W-1:0];
    end
  end

  always_comb begin
    code_nxt = TYPE_NONE;
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (ranked[r]) code_nxt = code_tbl[r];
    end
    if (!master_en) code_nxt = TYPE_NONE;
    req_any = master_en & (|ranked);
  end
endmodule

// File: rtl/irqarb_outreg.sv
module irqarb_outreg
  import irqarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_any,
  input  logic              ack,
  input  logic [TYPE_W-1:0] code_nxt,
  output logic              irq_req,
  output logic [TYPE_W-1:0] irq_type
);
  logic              req_nxt;
  logic              req_q;
  logic [TYPE_W-1:0] type_q;

  assign req_nxt = req_any & ~ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      type_q <= TYPE_NONE;
    end else begin
      if (req_nxt != req_q)   req_q  <= req_nxt;
      if (code_nxt != type_q) type_q <= code_nxt;
    end
  end

  assign irq_req  = req_q;
  assign irq_type = type_q;

  // R6
  ack_masks_req_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq_req);
  // R3
  req_has_type_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_type != TYPE_NONE));
endmodule

// File: rtl/irqarb_vec.sv
module irqarb_vec #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] vec
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst)     vec_q <= '0;
    else if (we) vec_q <= wdata;
  end

  assign vec = vec_q;

  // R7
  vec_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (vec == $past(wdata)));
  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(vec));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irqarb_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_en,
  input  logic [NUM_CH-1:0] tx_irq_en,
  input  logic [NUM_CH-1:0] tx_irq_pend,
  input  logic [NUM_CH-1:0] ext_irq_en,
  input  logic [NUM_CH-1:0] ext_irq_pend,
  input  logic              irq_ack,
  input  logic              vec_we,
  input  logic [VEC_W-1:0]  vec_wdata,
  output logic              irq_req,
  output logic [TYPE_W-1:0] irq_type,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int TOP_TX_CODE = TX_BASE + NUM_CH - 1;

  logic [NUM_CH-1:0] tx_act;
  logic [NUM_CH-1:0] ext_act;
  logic [TYPE_W-1:0] code_nxt;
  logic              req_any;

  irqarb_gate #(.NUM_CH(NUM_CH)) u_gate (
    .tx_en   (tx_irq_en),
    .tx_pend (tx_irq_pend),
    .ext_en  (ext_irq_en),
    .ext_pend(ext_irq_pend),
    .tx_act  (tx_act),
    .ext_act (ext_act)
  );

  irqarb_prio #(.NUM_CH(NUM_CH)) u_prio (
    .tx_act   (tx_act),
    .ext_act  (ext_act),
    .master_en(master_en),
    .code_nxt (code_nxt),
    .req_any  (req_any)
  );

  irqarb_outreg u_out (
    .clk     (clk),
    .rst     (rst),
    .req_any (req_any),
    .ack     (irq_ack),
    .code_nxt(code_nxt),
    .irq_req (irq_req),
    .irq_type(irq_type)
  );

  irqarb_vec #(.VEC_W(VEC_W)) u_vec (
    .clk  (clk),
    .rst  (rst),
    .we   (vec_we),
    .wdata(vec_wdata),
    .vec  (irq_vector)
  );

  // R4
  master_off_chk: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> (!irq_req && irq_type == TYPE_NONE));
  // R2
  top_source_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (master_en && tx_irq_en[NUM_CH-1] && tx_irq_pend[NUM_CH-1])
      |=> (irq_type == TOP_TX_CODE[TYPE_W-1:0]));
  // R1
  no_source_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_irq_en & tx_irq_pend) == '0 && (ext_irq_en & ext_irq_pend) == '0)
      |=> !irq_req);
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_en = 1'b0;
  logic [1:0] tx_en = '0, tx_pd = '0, ex_en = '0, ex_pd = '0;
  logic       ack = 1'b0;
  logic       vwe = 1'b0;
  logic [7:0] vdat = '0;
  logic       irq_req;
  logic [3:0] irq_type;
  logic [7:0] irq_vector;

  integer n_cmp = 0;
  integer n_bad = 0;
  string  cur_req = "R8";

  integer exp_irq = 0;
  integer exp_type = 0;
  integer exp_vec = 0;

  always #2.5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst(rst), .master_en(master_en),
    .tx_irq_en(tx_en), .tx_irq_pend(tx_pd),
    .ext_irq_en(ex_en), .ext_irq_pend(ex_pd),
    .irq_ack(ack), .vec_we(vwe), .vec_wdata(vdat),
    .irq_req(irq_req), .irq_type(irq_type), .irq_vector(irq_vector)
  );

  // behavioural reference: ranking and codes written from the requirements
  always @(posedge clk) begin
    integer t;
    if (rst) begin
      exp_irq  <= 0;
      exp_type <= 0;
      exp_vec  <= 0;
    end else begin
      t = 0;
      if (master_en) begin
        if (tx_en[1] && tx_pd[1])      t = 6;
        else if (tx_en[0] && tx_pd[0]) t = 5;
        else if (ex_en[1] && ex_pd[1]) t = 8;
        else if (ex_en[0] && ex_pd[0]) t = 7;
      end
      exp_type <= t;
      exp_irq  <= (t != 0 && !ack) ? 1 : 0;
      if (vwe) exp_vec <= vdat;
    end
  end

  task automatic cyc();
    @(negedge clk);
    n_cmp++;
    if (irq_req !== exp_irq[0] || irq_type !== exp_type[3:0] || irq_vector !== exp_vec[7:0]) begin
      n_bad++;
      $display("FAIL %s: irq=%0b type=%0d vec=%02h expected irq=%0d type=%0d vec=%02h",
               cur_req, irq_req, irq_type, irq_vector, exp_irq, exp_type, exp_vec);
    end
  endtask

  task automatic set_src(input logic [7:0] m);
    {tx_en, tx_pd, ex_en, ex_pd} = m;
  endtask

  initial begin
    #(5 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R8: reset state
    cur_req = "R8";
    repeat (3) cyc();
    rst = 1'b0;
    // R9: master on, nothing active
    cur_req = "R9";
    master_en = 1'b1;
    repeat (3) cyc();
    // R1: each single source with enable only, pending only, both
    cur_req = "R1";
    for (int s = 0; s < 4; s++) begin
      for (int k = 1; k < 4; k++) begin
        tx_en = '0; tx_pd = '0; ex_en = '0; ex_pd = '0;
        if (s < 2) begin tx_en[s] = k[0]; tx_pd[s] = k[1]; end
        else begin ex_en[s-2] = k[0]; ex_pd[s-2] = k[1]; end
        cyc(); cyc();
      end
    end
    // R3: each lone source gives its own code
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      set_src(8'h00);
      if (s < 2) begin tx_en[s] = 1'b1; tx_pd[s] = 1'b1; end
      else begin ex_en[s-2] = 1'b1; ex_pd[s-2] = 1'b1; end
      cyc(); cyc();
    end
    // R2: full sweep of enable/pending combinations
    cur_req = "R2";
    for (int m = 0; m < 256; m++) begin
      set_src(m[7:0]);
      cyc();
    end
    // R4: master off with all sources active, then back on
    cur_req = "R4";
    set_src(8'hFF);
    master_en = 1'b0;
    repeat (3) cyc();
    master_en = 1'b1; cyc();
    master_en = 1'b0; cyc();
    master_en = 1'b1; cyc(); cyc();
    // R6: acknowledge pulses with a source held active
    cur_req = "R6";
    set_src(8'h00); ex_en[0] = 1'b1; ex_pd[0] = 1'b1;
    cyc(); cyc();
    ack = 1'b1; cyc();
    ack = 1'b0; cyc(); cyc();
    ack = 1'b1; cyc(); cyc();
    tx_en[1] = 1'b1; tx_pd[1] = 1'b1; cyc();
    ack = 1'b0; cyc(); cyc();
    // R7: vector writes and hold
    cur_req = "R7";
    vdat = 8'hA5; vwe = 1'b1; cyc();
    vwe = 1'b0; vdat = 8'h3C; cyc(); cyc();
    vwe = 1'b1; cyc();
    vdat = 8'hFF; cyc();
    vwe = 1'b0; vdat = 8'h00; cyc(); cyc();
    // R8: reset in mid-run clears everything
    cur_req = "R8";
    set_src(8'hFF);
    rst = 1'b1; repeat (3) cyc();
    rst = 1'b0; cyc(); cyc();
    // R5: random mix compared every cycle
    cur_req = "R5";
    for (int i = 0; i < 4000; i++) begin
      set_src($urandom());
      master_en = ($urandom_range(0, 7) != 0);
      ack = ($urandom_range(0, 5) == 0);
      vwe = ($urandom_range(0, 3) == 0);
      vdat = $urandom();
      cyc();
    end
    ack = 1'b0; vwe = 1'b0;
    cyc();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule